// File: doc/BRIEF.md
# PHY Status Interrupt Controller

This block gathers single-cycle status-change pulses from up to eight event sources inside a PHY and holds each one in a sticky status bit. One 16-bit register carries both halves of the state. The upper byte holds the per-event enables and software can write it. The lower byte holds the latched status, which is read-only. A management read port, such as the one behind an MDIO slave, reads the whole word. Every read clears the status byte.

The block raises its interrupt whenever a latched status bit has its enable set. A separate polarity input selects how the interrupt reaches the pad. In active-low mode the block acts as an open-drain source: it drives low only while the interrupt is asserted and otherwise releases the line to a pull-up. In active-high mode it drives the level at all times. The block produces only the output value and the output-enable. The pad driver and the event logic are outside the block.

Top module: `phy_irq_ctl`

## Requirements
- R1: After reset the register reads 0x0000, and with irqActiveHigh=0 the block gives irqLevel=1 and irqDriveEn=0.
- R2: A pulse on evtIn[i] sets register bit i from the next clock edge, whatever the value of the matching enable bit i+8.
- R3: While accRd is high, accRdData shows {enables, status} as they stood before that read's clock edge. Enables are in bits [15:8] and status is in bits [7:0].
- R4: A read clears every status bit at the clock edge that ends the read cycle.
- R5: An event pulse in the same cycle as a clearing read leaves its status bit set after that edge.
- R6: A write (accWr) loads accWrData[15:8] into the enable byte. accWrData[7:0] has no effect, and a write does not change the status byte.
- R7: The interrupt is pending when some status bit i and enable bit i+8 are both 1. Setting an enable on a bit that is already latched makes the interrupt pending from the edge of that write.
- R8: With irqActiveHigh=0, a pending interrupt gives irqLevel=0 and irqDriveEn=1. When nothing is pending the block gives irqLevel=1 and irqDriveEn=0.
- R9: With irqActiveHigh=1, the block gives irqDriveEn=1 and irqLevel equal to the pending state.
- R10: A status bit stays set until a read, however many cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | 8 | One-cycle event pulses, one per source |
| accWr | input | 1 | Write strobe for the interrupt register |
| accRd | input | 1 | Read strobe; clears status at the edge |
| accWrData | input | 16 | Write data; only [15:8] is used |
| accRdData | output | 16 | Current register value {enables, status} |
| irqActiveHigh | input | 1 | Polarity select: 0 open-drain active low, 1 push-pull active high |
| irqLevel | output | 1 | Interrupt value toward the pad |
| irqDriveEn | output | 1 | Pad output-enable |

## Verification
A status bit that is wrongly set or lost shows on accRdData one edge after the event or read that caused it. If the mask is enabled, it also shows on irqLevel in that same cycle. A corrupted enable byte appears on the next read and changes the interrupt pin whenever the matching status bit is latched. The bench compares every output against a behavioural model on every clock. A divergence is therefore reported within one cycle of the cause. The bench exercises reads that collide with events and enables that are raised after latching.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  typedef struct packed {
    logic loadEnable;
    logic clrStatus;
  } irqStrobes_t;
endpackage

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int REG_W   = 16
) (
  input  logic               accWr,
  input  logic               accRd,
  input  logic [REG_W-1:0]   accWrData,
  output irqStrobes_t        strobes,
  output logic [NUM_EVT-1:0] wrEnable
);
  localparam int HALF = REG_W / 2;

  always_comb begin
    strobes.loadEnable = accWr;
    strobes.clrStatus  = accRd;
  end

  // Only the upper half of the write word carries the enables.
  assign wrEnable = accWrData[HALF +: NUM_EVT];
endmodule

// File: rtl/phy_irq_dp.sv
module phy_irq_dp
  import phy_irq_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int REG_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobes_t        strobes,
  input  logic [NUM_EVT-1:0] wrEnable,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               activeHigh,
  output logic [REG_W-1:0]   rdData,
  output logic               irqLevel,
  output logic               irqDriveEn
);
  localparam int HALF = REG_W / 2;

  logic [NUM_EVT-1:0] enableQ;
  logic [NUM_EVT-1:0] statusQ;
  logic               pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enableQ <= '0;
    else if (strobes.loadEnable) enableQ <= wrEnable;
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statusQ[i] <= 1'b0;
      else       statusQ[i] <= (statusQ[i] & ~strobes.clrStatus) | evtIn[i];
    end
  end

  always_comb begin
    rdData = '0;
    rdData[HALF +: NUM_EVT] = enableQ;
    rdData[NUM_EVT-1:0]     = statusQ;
  end

  assign pending = |(enableQ & statusQ);

  always_comb begin
    if (activeHigh) begin
      irqLevel   = pending;
      irqDriveEn = 1'b1;
    end else begin
      irqLevel   = ~pending;
      irqDriveEn = pending;
    end
  end
endmodule

// File: rtl/phy_irq_ctl.sv
module phy_irq_ctl
  import phy_irq_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int REG_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               accWr,
  input  logic               accRd,
  input  logic [REG_W-1:0]   accWrData,
  output logic [REG_W-1:0]   accRdData,
  input  logic               irqActiveHigh,
  output logic               irqLevel,
  output logic               irqDriveEn
);
  irqStrobes_t        strobes;
  logic [NUM_EVT-1:0] wrEnable;

  phy_irq_ctrl #(.NUM_EVT(NUM_EVT), .REG_W(REG_W)) ctrl_i (
    .accWr(accWr), .accRd(accRd), .accWrData(accWrData),
    .strobes(strobes), .wrEnable(wrEnable)
  );

  phy_irq_dp #(.NUM_EVT(NUM_EVT), .REG_W(REG_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrEnable(wrEnable),
    .evtIn(evtIn), .activeHigh(irqActiveHigh), .rdData(accRdData),
    .irqLevel(irqLevel), .irqDriveEn(irqDriveEn)
  );
endmodule

// File: rtl/phy_irq_ctl_chk.sv
module phy_irq_ctl_chk #(
  parameter int NUM_EVT = 8,
  parameter int REG_W   = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EVT-1:0] evtIn,
  input logic               accWr,
  input logic               accRd,
  input logic [REG_W-1:0]   accWrData,
  input logic [REG_W-1:0]   accRdData,
  input logic               irqActiveHigh,
  input logic               irqLevel,
  input logic               irqDriveEn
);
  localparam int HALF = REG_W / 2;
  logic [NUM_EVT-1:0] enView, stView;
  logic pendView;
  assign enView   = accRdData[HALF +: NUM_EVT];
  assign stView   = accRdData[NUM_EVT-1:0];
  assign pendView = |(enView & stView);

  // R4: a read with no event leaves status empty
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (accRd && evtIn == '0) |=> stView == '0);

  // R5 / R2: events are never lost
  a_r5_event_kept: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (stView & $past(evtIn)) == $past(evtIn));

  // R6: write loads enables
  a_r6_write_loads: assert property (@(posedge clk) disable iff (!rstN)
    accWr |=> enView == $past(accWrData[HALF +: NUM_EVT]));

  // R6: enables hold without a write
  a_r6_enable_hold: assert property (@(posedge clk) disable iff (!rstN)
    !accWr |=> $stable(enView));

  // R10: status sticky without a read
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !accRd |=> (stView & $past(stView)) == $past(stView));

  // R7 / R8: the pin follows enabled status in active-low mode
  a_r8_low_pin: assert property (@(posedge clk) disable iff (!rstN)
    !irqActiveHigh |-> (irqLevel == !pendView) && (irqDriveEn == pendView));

  // R9: the pin follows enabled status in active-high mode
  a_r9_high_pin: assert property (@(posedge clk) disable iff (!rstN)
    irqActiveHigh |-> (irqLevel == pendView) && irqDriveEn);
endmodule

bind phy_irq_ctl phy_irq_ctl_chk #(.NUM_EVT(NUM_EVT), .REG_W(REG_W)) chk_i (
  .clk(clk), .rstN(rstN), .evtIn(evtIn), .accWr(accWr), .accRd(accRd),
  .accWrData(accWrData), .accRdData(accRdData), .irqActiveHigh(irqActiveHigh),
  .irqLevel(irqLevel), .irqDriveEn(irqDriveEn)
);

// File: tb/phy_irq_ctl_tb_top.sv
module phy_irq_ctl_tb_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic [7:0]  evtIn = '0;
  logic        accWr = 0, accRd = 0;
  logic [15:0] accWrData = '0;
  logic [15:0] accRdData;
  logic        irqActiveHigh = 0;
  logic        irqLevel, irqDriveEn;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;
  logic [7:0] refEn = '0, refSt = '0;

  always #10 clk = ~clk;

  phy_irq_ctl dut_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .accWr(accWr), .accRd(accRd),
    .accWrData(accWrData), .accRdData(accRdData), .irqActiveHigh(irqActiveHigh),
    .irqLevel(irqLevel), .irqDriveEn(irqDriveEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compareAll();
    bit pend;
    pend = |(refEn & refSt);
    check(accRdData == {refEn, refSt}, "R3 register value", accRdData, {refEn, refSt});
    if (irqActiveHigh) begin
      check(irqLevel == pend && irqDriveEn == 1'b1, "R9 active-high pin",
            {irqLevel, irqDriveEn}, {pend, 1'b1});
    end else begin
      check(irqLevel == !pend && irqDriveEn == pend, "R8 active-low pin",
            {irqLevel, irqDriveEn}, {!pend, pend});
    end
  endtask

  // Drive one cycle of stimulus, compare against the model, then advance the model.
  task automatic step(input logic [7:0] e, input bit w, input bit r, input logic [15:0] d);
    @(negedge clk);
    evtIn = e; accWr = w; accRd = r; accWrData = d;
    #1 compareAll();
    @(posedge clk);
    if (w) refEn = d[15:8];
    refSt = (r ? 8'h00 : refSt) | e;
  endtask

  // Idle cycle with an explicit expected register value.
  task automatic expectReg(input string req, input logic [15:0] exp);
    @(negedge clk);
    evtIn = '0; accWr = 0; accRd = 0; accWrData = '0;
    #1 check(accRdData == exp, req, accRdData, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    #1 check(accRdData == 16'h0000, "R1 reset register", accRdData, 0);
    check(irqLevel == 1 && irqDriveEn == 0, "R1 reset pin", {irqLevel, irqDriveEn}, 2'b10);

    // R2: latch with enable off
    step(8'h08, 0, 0, 0);
    expectReg("R2 latch while disabled", 16'h0008);
    check(irqDriveEn == 0, "R2 no irq while disabled", irqDriveEn, 0);
    // R6: write ignores low byte and keeps status
    step(8'h00, 1, 0, 16'hA5FF);
    expectReg("R6 write enable only", 16'hA508);
    // R7: enabling a latched bit raises irq at once
    step(8'h00, 1, 0, 16'h0800);
    expectReg("R7 enable after latch", 16'h0808);
    check(irqLevel == 0 && irqDriveEn == 1, "R7 irq asserted", {irqLevel, irqDriveEn}, 2'b01);
    // R10: sticky across many cycles
    step(8'h41, 0, 0, 0);
    repeat (20) step(8'h00, 0, 0, 0);
    expectReg("R10 sticky", 16'h0849);
    // R4: read clears
    step(8'h00, 0, 1, 0);
    expectReg("R4 cleared", 16'h0800);
    check(irqLevel == 1 && irqDriveEn == 0, "R4 irq released", {irqLevel, irqDriveEn}, 2'b10);
    // R5: event with clearing read
    step(8'h02, 0, 0, 0);
    step(8'h08, 0, 1, 0);
    expectReg("R5 collision kept", 16'h0808);
    // R9: active-high polarity
    irqActiveHigh = 1;
    step(8'h00, 0, 0, 0);
    check(irqLevel == 1 && irqDriveEn == 1, "R9 high asserted", {irqLevel, irqDriveEn}, 2'b11);
    step(8'h00, 0, 1, 0);
    step(8'h00, 0, 0, 0);
    check(irqLevel == 0 && irqDriveEn == 1, "R9 high idle", {irqLevel, irqDriveEn}, 2'b01);

    // Mixed traffic under the model
    for (int k = 0; k < 600; k++) begin
      if (k == 300) irqActiveHigh = 0;
      step(8'($urandom) & 8'($urandom), ($urandom % 7) == 0, ($urandom % 5) == 0, 16'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule